// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block is one output channel of a timer's compare stage. It holds a single output register and decides, cycle by cycle, whether that register is set, cleared, toggled or left alone. The decision draws on four things: the compare-match, TOP and count-direction events delivered by an external counter, a 2-bit output mode field, and the 4-bit waveform mode of the timer. The same field selects set, clear or toggle actions when the timer is not generating PWM. In PWM modes it selects the output polarity instead.

The unit also computes a pin-override enable. The output register drives the pin only when the channel is connected and the data-direction bit marks the pin as an output. While the channel is disconnected the register can be preloaded, so the pin starts at a known level once it is enabled. A force strobe applies the match action at once in non-PWM modes. A parameter builds the unit as channel A, which can toggle in PWM modes where its own compare value sets TOP, or as channel B, which cannot.

Waveform mode codes fall into three classes. Codes 0, 4, 12 and 13 are non-PWM. Codes 5, 6, 7, 14 and 15 are single-slope PWM. Codes 1, 2, 3, 8, 9, 10 and 11 are dual-slope PWM. Codes 9, 11 and 15 are the modes in which channel A's compare value is TOP.

Top module: `cmp_wave_unit`

## Requirements
- R1: `pin_en` is 1 exactly when `dir_out` is 1 and the channel is connected. Field 00 is always disconnected. Field 01 in a PWM mode is disconnected unless the unit is channel A and the mode is 9, 11 or 15. Every other field value is connected.
- R2: While the channel is disconnected, `wave_out` holds its value, and a cycle with `preload_we` high loads `preload_val` on the next edge. While the channel is connected, `preload_we` is ignored.
- R3: In non-PWM modes, a cycle with `tick` and `match` high applies the field's action on the next edge: 01 toggles, 10 clears and 11 sets `wave_out`.
- R4: In single-slope modes, field 10 clears `wave_out` on a match and sets it on a TOP cycle. Field 11 does the opposite. With a compare value c below TOP, a counter period of TOP+1 cycles therefore holds `wave_out` high for c+1 cycles under field 10, and for TOP-c cycles under field 11.
- R5: In single-slope modes, a compare value equal to TOP makes the match have no effect, so only the TOP action applies: `wave_out` is high for the whole period under field 10 and low under field 11.
- R6: In dual-slope modes, field 10 clears `wave_out` on a match while counting up (`count_down`=0) and sets it on a match while counting down. Field 11 inverts both actions. Over a 2*TOP-cycle period, `wave_out` is high for 2*c cycles under field 10 and for 2*(TOP-c) cycles under field 11.
- R7: In dual-slope modes, under field 10 a compare value of 0 keeps `wave_out` low for the whole period and a compare value equal to TOP keeps it high. Field 11 gives the opposite levels.
- R8: Field 01 in modes 9, 11 or 15 makes channel A toggle on every ticked match. Channel B under field 01 in a PWM mode never changes `wave_out` and never asserts `pin_en`.
- R9: In non-PWM modes with the channel connected, `force_cmp` applies the field's match action on the next edge, even when `tick` is low. A coincident match produces only one action. In PWM modes `force_cmp` has no effect.
- R10: When `tick` is low, `match` and `at_top` have no effect on `wave_out`.
- R11: After reset `wave_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable; qualifies match and TOP events |
| wave_mode | input | 4 | Timer waveform mode code |
| out_mode | input | 2 | Compare output mode field |
| dir_out | input | 1 | Data-direction bit of the pin (1 = output) |
| match | input | 1 | Counter equals compare value this cycle |
| at_top | input | 1 | Counter equals TOP this cycle |
| count_down | input | 1 | Counter is on its falling slope (dual-slope modes) |
| cmp_val | input | CNT_W | Active compare value |
| top_val | input | CNT_W | Active TOP value |
| force_cmp | input | 1 | Force-compare strobe |
| preload_we | input | 1 | Write strobe for the output register |
| preload_val | input | 1 | Value loaded by `preload_we` |
| wave_out | output | 1 | Output register level |
| pin_en | output | 1 | Channel overrides the general port function |

## Verification
The hardest conditions to create are the compare-value edge cases of the PWM modes, a compare value equal to 0 or to TOP. In these cases the match coincides with TOP or BOTTOM, and the output must come out as a constant level rather than a pulse. The bench drives a counter model that reproduces the single-slope and dual-slope count sequences. It sweeps every compare value from 0 up to TOP under both polarities and measures the high time over a full settled period. The two channel variants are built side by side and share stimulus, so the toggle that only channel A has can be seen against a channel B that must stay still.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

   typedef enum logic [1:0] {
      CLS_NONPWM = 2'd0,
      CLS_SINGLE = 2'd1,
      CLS_DUAL   = 2'd2
   } wave_cls_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } wave_act_e;

   localparam logic [1:0] FLD_OFF = 2'b00;
   localparam logic [1:0] FLD_TGL = 2'b01;
   localparam logic [1:0] FLD_NRM = 2'b10;
   localparam logic [1:0] FLD_INV = 2'b11;

   function automatic wave_cls_e classify(input logic [3:0] mode);
      case (mode)
         4'd5, 4'd6, 4'd7, 4'd14, 4'd15:             classify = CLS_SINGLE;
         4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11: classify = CLS_DUAL;
         default:                                    classify = CLS_NONPWM;
      endcase
   endfunction

   function automatic logic own_top(input logic [3:0] mode);
      own_top = (mode == 4'd9) || (mode == 4'd11) || (mode == 4'd15);
   endfunction

endpackage

// File: rtl/cwu_mode_decode.sv
module cwu_mode_decode
   import cwu_pkg::*;
#(
   parameter bit IS_CHAN_A = 1'b1
) (
   input  logic [3:0] wave_mode,
   input  logic [1:0] out_mode,
   output wave_cls_e  cls,
   output logic       tgl_ok,
   output logic       conn
);

   assign cls = classify(wave_mode);

   generate
      if (IS_CHAN_A) begin : g_chan_a
         assign tgl_ok = (cls == CLS_NONPWM) || own_top(wave_mode);
      end else begin : g_chan_b
         assign tgl_ok = (cls == CLS_NONPWM);
      end
   endgenerate

   always_comb begin
      case (out_mode)
         FLD_OFF: conn = 1'b0;
         FLD_TGL: conn = tgl_ok;
         default: conn = 1'b1;
      endcase
   end

endmodule

// File: rtl/cwu_action_sel.sv
module cwu_action_sel
   import cwu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  wave_cls_e          cls,
   input  logic               conn,
   input  logic [1:0]         out_mode,
   input  logic               tick,
   input  logic               match,
   input  logic               at_top,
   input  logic               count_down,
   input  logic               force_cmp,
   input  logic [CNT_W-1:0]   cmp_val,
   input  logic [CNT_W-1:0]   top_val,
   output wave_act_e          act
);

   localparam logic [CNT_W-1:0] BOTTOM = '0;

   logic      hit;
   logic      wrap;
   logic      eq_top;
   logic      eq_bot;
   logic      inv;
   wave_act_e np_act;
   wave_act_e ss_act;
   wave_act_e ds_act;

   assign hit    = tick & match;
   assign wrap   = tick & at_top;
   assign eq_top = (cmp_val == top_val);
   assign eq_bot = (cmp_val == BOTTOM);
   assign inv    = (out_mode == FLD_INV);

   always_comb begin
      np_act = ACT_HOLD;
      if (hit || force_cmp) begin
         case (out_mode)
            FLD_TGL: np_act = ACT_TGL;
            FLD_NRM: np_act = ACT_CLR;
            FLD_INV: np_act = ACT_SET;
            default: np_act = ACT_HOLD;
         endcase
      end
   end

   always_comb begin
      ss_act = ACT_HOLD;
      if (out_mode == FLD_TGL) begin
         if (hit) ss_act = ACT_TGL;
      end else if (wrap) begin
         ss_act = inv ? ACT_CLR : ACT_SET;
      end else if (hit && !eq_top) begin
         ss_act = inv ? ACT_SET : ACT_CLR;
      end
   end

   always_comb begin
      logic lvl;
      lvl    = 1'b0;
      ds_act = ACT_HOLD;
      if (hit) begin
         if (out_mode == FLD_TGL) begin
            ds_act = ACT_TGL;
         end else begin
            if (eq_top)      lvl = 1'b1;
            else if (eq_bot) lvl = 1'b0;
            else             lvl = count_down;
            ds_act = (lvl ^ inv) ? ACT_SET : ACT_CLR;
         end
      end
   end

   always_comb begin
      if (!conn) begin
         act = ACT_HOLD;
      end else begin
         case (cls)
            CLS_SINGLE: act = ss_act;
            CLS_DUAL:   act = ds_act;
            default:    act = np_act;
         endcase
      end
   end

endmodule

// File: rtl/cwu_out_reg.sv
module cwu_out_reg
   import cwu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      conn,
   input  wave_act_e act,
   input  logic      preload_we,
   input  logic      preload_val,
   output logic      q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (conn) begin
         case (act)
            ACT_SET: q <= 1'b1;
            ACT_CLR: q <= 1'b0;
            ACT_TGL: q <= ~q;
            default: q <= q;
         endcase
      end else if (preload_we) begin
         q <= preload_val;
      end
   end

   AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!conn && !preload_we) |=> $stable(q)); // R2

   AST_CONN_NO_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (conn && act == ACT_HOLD) |=> $stable(q)); // R2

endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
   import cwu_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter bit IS_CHAN_A = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [3:0]       wave_mode,
   input  logic [1:0]       out_mode,
   input  logic             dir_out,
   input  logic             match,
   input  logic             at_top,
   input  logic             count_down,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] top_val,
   input  logic             force_cmp,
   input  logic             preload_we,
   input  logic             preload_val,
   output logic             wave_out,
   output logic             pin_en
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("cmp_wave_unit: CNT_W must be at least 2");
      end
   endgenerate

   wave_cls_e cls;
   wave_act_e act;
   logic      tgl_ok;
   logic      conn;

   cwu_mode_decode #(.IS_CHAN_A(IS_CHAN_A)) u_dec (
      .wave_mode (wave_mode),
      .out_mode  (out_mode),
      .cls       (cls),
      .tgl_ok    (tgl_ok),
      .conn      (conn)
   );

   cwu_action_sel #(.CNT_W(CNT_W)) u_act (
      .cls        (cls),
      .conn       (conn),
      .out_mode   (out_mode),
      .tick       (tick),
      .match      (match),
      .at_top     (at_top),
      .count_down (count_down),
      .force_cmp  (force_cmp),
      .cmp_val    (cmp_val),
      .top_val    (top_val),
      .act        (act)
   );

   cwu_out_reg u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .conn        (conn),
      .act         (act),
      .preload_we  (preload_we),
      .preload_val (preload_val),
      .q           (wave_out)
   );

   assign pin_en = conn & dir_out;

   AST_PIN_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      pin_en |-> (dir_out && out_mode != FLD_OFF)); // R1

   AST_SS_TOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_SINGLE && out_mode == FLD_NRM && tick && at_top) |=> wave_out); // R4

   AST_DS_EQ_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_DUAL && out_mode == FLD_NRM && tick && match && cmp_val == top_val)
      |=> wave_out); // R7

   AST_PWM_FORCE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cls != CLS_NONPWM && force_cmp && !tick && !preload_we) |=> $stable(wave_out)); // R9

   AST_NOTICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !force_cmp && !preload_we) |=> $stable(wave_out)); // R10

endmodule

// File: tb/cmp_wave_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_wave_unit_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         t_tick = 1'b0;
   logic [3:0]   t_mode = '0;
   logic [1:0]   t_field = '0;
   logic         t_dir = 1'b0;
   logic         t_match = 1'b0;
   logic         t_top = 1'b0;
   logic         t_down = 1'b0;
   logic [W-1:0] t_cmp = '0;
   logic [W-1:0] t_topv = '0;
   logic         t_force = 1'b0;
   logic         t_pl_we = 1'b0;
   logic         t_pl_val = 1'b0;
   logic         wave_a, pin_a, wave_b, pin_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmp_wave_unit #(.CNT_W(W), .IS_CHAN_A(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(t_tick), .wave_mode(t_mode), .out_mode(t_field),
      .dir_out(t_dir), .match(t_match), .at_top(t_top), .count_down(t_down),
      .cmp_val(t_cmp), .top_val(t_topv), .force_cmp(t_force), .preload_we(t_pl_we),
      .preload_val(t_pl_val), .wave_out(wave_a), .pin_en(pin_a)
   );

   cmp_wave_unit #(.CNT_W(W), .IS_CHAN_A(1'b0)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .tick(t_tick), .wave_mode(t_mode), .out_mode(t_field),
      .dir_out(t_dir), .match(t_match), .at_top(t_top), .count_down(t_down),
      .cmp_val(t_cmp), .top_val(t_topv), .force_cmp(t_force), .preload_we(t_pl_we),
      .preload_val(t_pl_val), .wave_out(wave_b), .pin_en(pin_b)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // inputs are set before the call; outputs are read after the following edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      t_tick = 0; t_match = 0; t_top = 0; t_down = 0; t_force = 0; t_pl_we = 0;
   endtask

   function automatic bit is_pwm(input int m);
      return (m inside {1, 2, 3, 5, 6, 7, 8, 9, 10, 11, 14, 15});
   endfunction

   // single-slope: counter 0..top, returns high cycles over the third period
   task automatic run_ss(input int top, output int hi);
      hi = 0;
      for (int p = 0; p < 3; p++) begin
         for (int c = 0; c <= top; c++) begin
            t_tick = 1; t_down = 0;
            t_match = (c == int'(t_cmp));
            t_top = (c == top);
            cyc();
            if (p == 2) hi += int'(wave_a);
         end
      end
      idle();
   endtask

   // dual-slope: up 0..top, down top-1..1
   task automatic run_ds(input int top, output int hi);
      hi = 0;
      for (int p = 0; p < 3; p++) begin
         for (int s = 0; s < 2 * top; s++) begin
            int c;
            c = (s <= top) ? s : 2 * top - s;
            t_tick = 1;
            t_down = (s > top);
            t_match = (c == int'(t_cmp));
            t_top = (c == top);
            cyc();
            if (p == 2) hi += int'(wave_a);
         end
      end
      idle();
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi;
      int top;
      bit prev;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check("R11 reset wave_a", int'(wave_a), 0);
      check("R11 reset wave_b", int'(wave_b), 0);

      // R1 exhaustive pin enable
      for (int m = 0; m < 16; m++) begin
         for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < 2; d++) begin
               bit ca, cb;
               t_mode = 4'(m); t_field = 2'(f); t_dir = d[0];
               #0.5;
               ca = (f != 0) && !(f == 1 && is_pwm(m) && !(m == 9 || m == 11 || m == 15));
               cb = (f != 0) && !(f == 1 && is_pwm(m));
               check("R1 pin_en chan A", int'(pin_a), int'(ca & d[0]));
               check("R1 pin_en chan B", int'(pin_b), int'(cb & d[0]));
            end
         end
      end
      @(negedge clk);
      t_dir = 1;

      // R2 preload while disconnected, ignored while connected
      t_mode = 4'd0; t_field = 2'b00;
      t_pl_we = 1; t_pl_val = 1; cyc(); idle();
      check("R2 preload loads 1", int'(wave_a), 1);
      t_tick = 1; t_match = 1; t_top = 1; cyc(); idle();
      check("R2 disconnected match holds", int'(wave_a), 1);
      t_pl_we = 1; t_pl_val = 0; cyc(); idle();
      check("R2 preload loads 0", int'(wave_a), 0);
      t_field = 2'b11; t_pl_we = 1; t_pl_val = 1; cyc(); idle();
      check("R2 preload ignored when connected", int'(wave_a), 0);

      // R3 non-PWM actions, CTC-like mode 4
      t_mode = 4'd4;
      t_field = 2'b11; t_tick = 1; t_match = 1; cyc(); idle();
      check("R3 set on match", int'(wave_a), 1);
      t_field = 2'b10; t_tick = 1; t_match = 1; cyc(); idle();
      check("R3 clear on match", int'(wave_a), 0);
      t_field = 2'b01;
      for (int k = 0; k < 4; k++) begin
         prev = wave_a;
         t_tick = 1; t_match = 1; cyc(); idle();
         check("R3 toggle on match", int'(wave_a), int'(!prev));
      end
      t_tick = 1; t_match = 0; cyc(); idle();
      check("R3 no match holds", int'(wave_a), 0);

      // R10 tick low: match ignored
      t_mode = 4'd0; t_field = 2'b11;
      t_tick = 0; t_match = 1; t_top = 1; cyc(); idle();
      check("R10 no tick match ignored", int'(wave_a), 0);
      t_mode = 4'd14; t_field = 2'b10;
      t_tick = 0; t_top = 1; cyc(); idle();
      check("R10 no tick top ignored", int'(wave_a), 0);

      // R9 force in non-PWM, none in PWM
      t_mode = 4'd12; t_field = 2'b11; t_force = 1; cyc(); idle();
      check("R9 force set", int'(wave_a), 1);
      t_field = 2'b10; t_force = 1; cyc(); idle();
      check("R9 force clear", int'(wave_a), 0);
      t_field = 2'b01; t_force = 1; t_tick = 1; t_match = 1; cyc(); idle();
      check("R9 force with match toggles once", int'(wave_a), 1);
      t_mode = 4'd5; t_field = 2'b10; t_force = 1; cyc(); idle();
      check("R9 force no effect single-slope", int'(wave_a), 1);
      t_mode = 4'd1; t_field = 2'b10; t_force = 1; cyc(); idle();
      check("R9 force no effect dual-slope", int'(wave_a), 1);

      // R4 / R5 single-slope duty sweep
      top = 7;
      t_mode = 4'd14; t_topv = 4'(top);
      for (int pol = 0; pol < 2; pol++) begin
         t_field = pol ? 2'b11 : 2'b10;
         for (int c = 0; c <= top; c++) begin
            int exp_hi;
            t_cmp = 4'(c);
            run_ss(top, hi);
            exp_hi = (c == top) ? top + 1 : c + 1;
            if (pol) exp_hi = top + 1 - exp_hi;
            if (c == top) check(pol ? "R5 single-slope cmp=TOP inverted" : "R5 single-slope cmp=TOP", hi, exp_hi);
            else          check(pol ? "R4 single-slope duty inverted" : "R4 single-slope duty", hi, exp_hi);
         end
      end

      // R6 / R7 dual-slope duty sweep
      t_mode = 4'd10;
      for (int pol = 0; pol < 2; pol++) begin
         t_field = pol ? 2'b11 : 2'b10;
         for (int c = 0; c <= top; c++) begin
            int exp_hi;
            t_cmp = 4'(c);
            run_ds(top, hi);
            exp_hi = pol ? 2 * (top - c) : 2 * c;
            if (c == 0 || c == top) check("R7 dual-slope edge compare", hi, exp_hi);
            else                    check("R6 dual-slope duty", hi, exp_hi);
         end
      end

      // R8 channel A toggle when it owns TOP, channel B idle
      top = 3;
      t_topv = 4'(top); t_cmp = 4'(top);
      t_mode = 4'd15; t_field = 2'b01;
      t_pl_we = 0;
      prev = wave_b;
      for (int p = 0; p < 4; p++) begin
         bit a0;
         a0 = wave_a;
         for (int c = 0; c <= top; c++) begin
            t_tick = 1; t_down = 0; t_match = (c == top); t_top = (c == top);
            cyc();
         end
         check("R8 chan A toggles per period", int'(wave_a), int'(!a0));
         check("R8 chan B holds", int'(wave_b), int'(prev));
         check("R8 chan B pin off", int'(pin_b), 0);
      end
      idle();
      t_mode = 4'd9;
      for (int k = 0; k < 2; k++) begin
         bit a0;
         a0 = wave_a;
         t_tick = 1; t_match = 1; cyc(); idle();
         check("R8 chan A toggles mode 9", int'(wave_a), int'(!a0));
      end
      t_mode = 4'd14;
      prev = wave_a;
      t_tick = 1; t_match = 1; cyc(); idle();
      check("R8 chan A no toggle mode 14", int'(wave_a), int'(prev));

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule